// File: doc/BRIEF.md
# State Save Instruction Fault Checker

This block sits beside the decode and address-generation logic for a processor's state-save instruction. It decides whether the instruction may run. If it may not, it reports the single exception that must be raised. Each request arrives on a one-cycle strobe and carries the following inputs:

- the feature-support flags and the OS-enable control bit;
- the task-switched control bit and the decoded prefix flags;
- the current processor mode and the effective address;
- the results of the segment-limit and canonical-address comparisons made elsewhere;
- a flag that says whether the access goes through the stack segment;
- a page-fault flag and its fault code, both supplied by the translation logic.

One cycle after the strobe, the block shows the verdict on its registered outputs for exactly one cycle. The verdict is an exception code and an error code.

A small state machine holds the verdict. It has three states:

- `ST_IDLE`: no result is on the outputs.
- `ST_CLEAR`: the last request may execute.
- `ST_TRAP`: the last request raises an exception.

Every state moves to `ST_CLEAR` or `ST_TRAP` on a strobe, according to the priority-resolved code. Every state moves to `ST_IDLE` when there is no strobe. The priority tiers, from highest to lowest, are:

1. undefined opcode;
2. device not available;
3. general protection or stack fault;
4. page fault.

The address tier applies an alignment rule that does not depend on mode. It then applies a check that depends on mode:

- real mode: a range check against 64 KiB;
- protected mode: the segment-limit results;
- 64-bit mode: the canonical-address result, which is split between stack and general faults.

Top module: `ssave_fault_check`

## Requirements
- R1: After reset, res_valid and res_fault are 0, exc_code is 0 (none) and err_code is 0.
- R2: A request strobed on req_valid in cycle N gives res_valid high in cycle N+1 only, unless another strobe follows. Back-to-back strobes give back-to-back results.
- R3: exc_code is 1 (undefined opcode) when feat_base is 0, feat_opt is 0 or os_enable is 0.
- R4: exc_code is 1 (undefined opcode) when any of pfx_lock, pfx_66, pfx_f3 or pfx_f2 is 1.
- R5: exc_code is 2 (device not available) when task_sw is 1 and no undefined-opcode condition holds. An undefined-opcode condition takes precedence over task_sw.
- R6: When eff_addr[5:0] is nonzero, exc_code is 3 (general protection) with err_code 0, in every mode. This ranks above every limit, range, canonical and page-fault input.
- R7: Real mode is cpu_mode 0. In real mode, a general-protection fault (code 3) is raised when eff_addr + OPSIZE - 1 exceeds FFFFh. The inputs seg_limit_bad, ss_limit_bad and noncanon have no effect in this mode.
- R8: Protected mode is cpu_mode 1. In protected mode, seg_limit_bad gives code 3 and ss_limit_bad gives code 4 (stack fault). When both are set, code 3 is reported. noncanon has no effect in this mode.
- R9: 64-bit mode is cpu_mode 2 or 3. In this mode, noncanon with uses_stack gives code 4, and noncanon without uses_stack gives code 3. The limit inputs have no effect in this mode.
- R10: When no higher-tier condition holds, pf_hit gives exc_code 5 (page fault) with err_code equal to the pf_code of the request.
- R11: A request with no fault condition gives exc_code 0, res_fault 0 and err_code 0.
- R12: Whenever res_valid is 1, two things hold. err_code is 0 for every code except 5. res_fault is 1 exactly when exc_code is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle request strobe |
| feat_base | input | 1 | Basic state-save feature supported |
| feat_opt | input | 1 | Optimised state-save feature supported |
| os_enable | input | 1 | OS has enabled extended state saving |
| task_sw | input | 1 | Task-switched control bit |
| pfx_lock | input | 1 | LOCK prefix decoded |
| pfx_66 | input | 1 | 66h prefix decoded |
| pfx_f3 | input | 1 | F3h prefix decoded |
| pfx_f2 | input | 1 | F2h prefix decoded |
| cpu_mode | input | 2 | 0 real, 1 protected, 2 or 3 64-bit |
| eff_addr | input | AW | Effective address of the save area |
| seg_limit_bad | input | 1 | Code or data segment limit exceeded |
| ss_limit_bad | input | 1 | Stack segment limit exceeded |
| noncanon | input | 1 | Address is non-canonical |
| uses_stack | input | 1 | Access references the stack segment |
| pf_hit | input | 1 | Translation reported a page fault |
| pf_code | input | ERRW | Page-fault error code |
| res_valid | output | 1 | Verdict valid |
| res_fault | output | 1 | Verdict is an exception |
| exc_code | output | 3 | Exception code (0 none, 1 UD, 2 NM, 3 GP, 4 SS, 5 PF) |
| err_code | output | ERRW | Error code pushed with the exception |

## Verification
The assertions check the following on every cycle:

- the one-cycle result timing;
- that the undefined-opcode and device-not-available tiers win over everything below them;
- that a misaligned address always yields a general-protection fault with a zero error code;
- that the page-fault error code follows the request;
- the agreement between res_fault, exc_code and err_code.

Some behaviours can only be shown by the bench's scenarios:

- the mode-dependent handling, that is, which inputs are ignored in which mode;
- the real-mode range boundary at the largest legal aligned address;
- the choice between stack and general faults;
- the ordering inside the address tier.

// File: rtl/ssf_pkg.sv
package ssf_pkg;

    typedef enum logic [2:0] {
        EXC_NONE = 3'd0,
        EXC_UD   = 3'd1,
        EXC_NM   = 3'd2,
        EXC_GP   = 3'd3,
        EXC_SS   = 3'd4,
        EXC_PF   = 3'd5
    } exc_e;

    typedef enum logic [1:0] {
        MODE_REAL = 2'd0,
        MODE_PROT = 2'd1,
        MODE_LONG = 2'd2,
        MODE_LALT = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CLEAR = 2'd1,
        ST_TRAP  = 2'd2
    } state_e;

    localparam int NUM_PFX = 4;

endpackage

// File: rtl/ssf_gate_check.sv
module ssf_gate_check
    import ssf_pkg::*;
#(
    parameter int NPFX = NUM_PFX
) (
    input  logic            feat_base,
    input  logic            feat_opt,
    input  logic            os_enable,
    input  logic            task_sw,
    input  logic [NPFX-1:0] pfx_vec,
    output logic            ud_hit,
    output logic            nm_hit
);

    logic [NPFX:0] pfx_chain;
    logic          feat_miss;

    assign pfx_chain[0] = 1'b0;

    // One OR stage per prefix flag.
    generate
        for (genvar i = 0; i < NPFX; i++) begin : g_pfx
            assign pfx_chain[i+1] = pfx_chain[i] | pfx_vec[i];
        end
    endgenerate

    always_comb begin
        feat_miss = !feat_base || !feat_opt || !os_enable;
        ud_hit    = feat_miss || pfx_chain[NPFX];
        nm_hit    = task_sw;
    end

endmodule

// File: rtl/ssf_addr_check.sv
module ssf_addr_check
    import ssf_pkg::*;
#(
    parameter int AW       = 64,
    parameter int OPSIZE   = 576,
    parameter int ALIGN_LG = 6
) (
    input  logic [1:0]    cpu_mode,
    input  logic [AW-1:0] eff_addr,
    input  logic          seg_limit_bad,
    input  logic          ss_limit_bad,
    input  logic          noncanon,
    input  logic          uses_stack,
    output logic          gp_hit,
    output logic          ss_hit
);

    // Highest start address whose last byte still fits below 64 KiB.
    localparam logic [AW-1:0] REAL_TOP = AW'(65536 - OPSIZE);

    mode_e mode;
    logic  misalign;
    logic  real_over;
    logic  mode_gp;
    logic  mode_ss;

    always_comb begin
        mode      = mode_e'(cpu_mode);
        misalign  = |eff_addr[ALIGN_LG-1:0];
        real_over = eff_addr > REAL_TOP;
        mode_gp   = 1'b0;
        mode_ss   = 1'b0;
        unique case (mode)
            MODE_REAL: begin
                mode_gp = real_over;
            end
            MODE_PROT: begin
                mode_gp = seg_limit_bad;
                mode_ss = ss_limit_bad && !seg_limit_bad;
            end
            MODE_LONG, MODE_LALT: begin
                mode_gp = noncanon && !uses_stack;
                mode_ss = noncanon && uses_stack;
            end
            default: begin
                mode_gp = 1'b0;
                mode_ss = 1'b0;
            end
        endcase
        gp_hit = misalign || mode_gp;
        ss_hit = !misalign && mode_ss;
    end

endmodule

// File: rtl/ssf_arbiter.sv
module ssf_arbiter
    import ssf_pkg::*;
#(
    parameter int ERRW = 32
) (
    input  logic            ud_hit,
    input  logic            nm_hit,
    input  logic            gp_hit,
    input  logic            ss_hit,
    input  logic            pf_hit,
    input  logic [ERRW-1:0] pf_code,
    output exc_e            win_code,
    output logic [ERRW-1:0] win_err
);

    always_comb begin
        win_err = '0;
        if (ud_hit) begin
            win_code = EXC_UD;
        end else if (nm_hit) begin
            win_code = EXC_NM;
        end else if (gp_hit) begin
            win_code = EXC_GP;
        end else if (ss_hit) begin
            win_code = EXC_SS;
        end else if (pf_hit) begin
            win_code = EXC_PF;
            win_err  = pf_code;
        end else begin
            win_code = EXC_NONE;
        end
    end

endmodule

// File: rtl/ssave_fault_check.sv
module ssave_fault_check
    import ssf_pkg::*;
#(
    parameter int AW       = 64,
    parameter int ERRW     = 32,
    parameter int OPSIZE   = 576,
    parameter int ALIGN_LG = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            feat_base,
    input  logic            feat_opt,
    input  logic            os_enable,
    input  logic            task_sw,
    input  logic            pfx_lock,
    input  logic            pfx_66,
    input  logic            pfx_f3,
    input  logic            pfx_f2,
    input  logic [1:0]      cpu_mode,
    input  logic [AW-1:0]   eff_addr,
    input  logic            seg_limit_bad,
    input  logic            ss_limit_bad,
    input  logic            noncanon,
    input  logic            uses_stack,
    input  logic            pf_hit,
    input  logic [ERRW-1:0] pf_code,
    output logic            res_valid,
    output logic            res_fault,
    output logic [2:0]      exc_code,
    output logic [ERRW-1:0] err_code
);

    state_e          state_q;
    state_e          state_d;
    logic            ud_hit;
    logic            nm_hit;
    logic            gp_hit;
    logic            ss_hit;
    exc_e            win_code;
    logic [ERRW-1:0] win_err;
    exc_e            code_q;
    logic [ERRW-1:0] err_q;

    ssf_gate_check #(.NPFX(NUM_PFX)) u_gate (
        .feat_base (feat_base),
        .feat_opt  (feat_opt),
        .os_enable (os_enable),
        .task_sw   (task_sw),
        .pfx_vec   ({pfx_f2, pfx_f3, pfx_66, pfx_lock}),
        .ud_hit    (ud_hit),
        .nm_hit    (nm_hit)
    );

    ssf_addr_check #(.AW(AW), .OPSIZE(OPSIZE), .ALIGN_LG(ALIGN_LG)) u_addr (
        .cpu_mode      (cpu_mode),
        .eff_addr      (eff_addr),
        .seg_limit_bad (seg_limit_bad),
        .ss_limit_bad  (ss_limit_bad),
        .noncanon      (noncanon),
        .uses_stack    (uses_stack),
        .gp_hit        (gp_hit),
        .ss_hit        (ss_hit)
    );

    ssf_arbiter #(.ERRW(ERRW)) u_arb (
        .ud_hit   (ud_hit),
        .nm_hit   (nm_hit),
        .gp_hit   (gp_hit),
        .ss_hit   (ss_hit),
        .pf_hit   (pf_hit),
        .pf_code  (pf_code),
        .win_code (win_code),
        .win_err  (win_err)
    );

    // Transitions: any state goes to CLEAR or TRAP on a strobe, else to IDLE.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_CLEAR, ST_TRAP: begin
                if (!req_valid)
                    state_d = ST_IDLE;
                else if (win_code == EXC_NONE)
                    state_d = ST_CLEAR;
                else
                    state_d = ST_TRAP;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Verdict capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= EXC_NONE;
            err_q  <= '0;
        end else if (req_valid) begin
            code_q <= win_code;
            err_q  <= win_err;
        end
    end

    always_comb begin
        res_valid = (state_q != ST_IDLE);
        res_fault = (state_q == ST_TRAP);
        exc_code  = code_q;
        err_code  = err_q;
    end

endmodule

// File: rtl/ssf_checker.sv
module ssf_checker
    import ssf_pkg::*;
#(
    parameter int AW       = 64,
    parameter int ERRW     = 32,
    parameter int ALIGN_LG = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            feat_base,
    input logic            feat_opt,
    input logic            os_enable,
    input logic            task_sw,
    input logic            pfx_lock,
    input logic            pfx_66,
    input logic            pfx_f3,
    input logic            pfx_f2,
    input logic [AW-1:0]   eff_addr,
    input logic [ERRW-1:0] pf_code,
    input logic            res_valid,
    input logic            res_fault,
    input logic [2:0]      exc_code,
    input logic [ERRW-1:0] err_code
);

    logic gate_ok;
    assign gate_ok = feat_base && feat_opt && os_enable &&
                     !pfx_lock && !pfx_66 && !pfx_f3 && !pfx_f2;

    assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    assert_result_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);

    assert_feature_ud_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (!feat_base || !feat_opt || !os_enable) |=> exc_code == EXC_UD);

    assert_prefix_ud_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (pfx_lock || pfx_66 || pfx_f3 || pfx_f2) |=> exc_code == EXC_UD);

    assert_task_nm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && gate_ok && task_sw |=> exc_code == EXC_NM);

    assert_misalign_gp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && gate_ok && !task_sw && (|eff_addr[ALIGN_LG-1:0])
        |=> exc_code == EXC_GP && err_code == '0);

    assert_pf_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (exc_code != EXC_PF) || (err_code == $past(pf_code)));

    assert_err_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && exc_code != EXC_PF |-> err_code == '0);

    assert_fault_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> res_fault == (exc_code != EXC_NONE));

endmodule

bind ssave_fault_check ssf_checker #(.AW(AW), .ERRW(ERRW), .ALIGN_LG(ALIGN_LG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .feat_base (feat_base),
    .feat_opt  (feat_opt),
    .os_enable (os_enable),
    .task_sw   (task_sw),
    .pfx_lock  (pfx_lock),
    .pfx_66    (pfx_66),
    .pfx_f3    (pfx_f3),
    .pfx_f2    (pfx_f2),
    .eff_addr  (eff_addr),
    .pf_code   (pf_code),
    .res_valid (res_valid),
    .res_fault (res_fault),
    .exc_code  (exc_code),
    .err_code  (err_code)
);

// File: tb/ssave_fault_check_tb.sv
module ssave_fault_check_tb;

    localparam int AW     = 64;
    localparam int ERRW   = 32;
    localparam int OPSIZE = 576;

    localparam logic [2:0] C_NONE = 3'd0;
    localparam logic [2:0] C_UD   = 3'd1;
    localparam logic [2:0] C_NM   = 3'd2;
    localparam logic [2:0] C_GP   = 3'd3;
    localparam logic [2:0] C_SS   = 3'd4;
    localparam logic [2:0] C_PF   = 3'd5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            feat_base, feat_opt, os_enable, task_sw;
    logic            pfx_lock, pfx_66, pfx_f3, pfx_f2;
    logic [1:0]      cpu_mode;
    logic [AW-1:0]   eff_addr;
    logic            seg_limit_bad, ss_limit_bad, noncanon, uses_stack, pf_hit;
    logic [ERRW-1:0] pf_code;
    logic            res_valid, res_fault;
    logic [2:0]      exc_code;
    logic [ERRW-1:0] err_code;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    ssave_fault_check #(.AW(AW), .ERRW(ERRW), .OPSIZE(OPSIZE)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .feat_base(feat_base), .feat_opt(feat_opt), .os_enable(os_enable),
        .task_sw(task_sw), .pfx_lock(pfx_lock), .pfx_66(pfx_66),
        .pfx_f3(pfx_f3), .pfx_f2(pfx_f2), .cpu_mode(cpu_mode),
        .eff_addr(eff_addr), .seg_limit_bad(seg_limit_bad),
        .ss_limit_bad(ss_limit_bad), .noncanon(noncanon),
        .uses_stack(uses_stack), .pf_hit(pf_hit), .pf_code(pf_code),
        .res_valid(res_valid), .res_fault(res_fault),
        .exc_code(exc_code), .err_code(err_code)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic clean(input logic [1:0] mode);
        feat_base = 1; feat_opt = 1; os_enable = 1; task_sw = 0;
        pfx_lock = 0; pfx_66 = 0; pfx_f3 = 0; pfx_f2 = 0;
        cpu_mode = mode; eff_addr = 64'h1000;
        seg_limit_bad = 0; ss_limit_bad = 0; noncanon = 0; uses_stack = 0;
        pf_hit = 0; pf_code = 32'h0;
    endtask

    // Strobe one request; sample one cycle later, away from the edge.
    task automatic fire_expect(input string tag, input logic [2:0] code, input logic [ERRW-1:0] err);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"}, 64'(res_valid), 64'd1);
        check({tag, " code"},  64'(exc_code), 64'(code));
        check({tag, " err"},   64'(err_code), 64'(err));
        check({tag, " fault"}, 64'(res_fault), 64'(code != C_NONE));
    endtask

    task automatic t_reset();
        check("R1 valid", 64'(res_valid), 0);
        check("R1 fault", 64'(res_fault), 0);
        check("R1 code",  64'(exc_code), 0);
        check("R1 err",   64'(err_code), 0);
    endtask

    task automatic t_timing();
        clean(2'd2);
        fire_expect("R2 first", C_NONE, 0);
        @(negedge clk);
        check("R2 drops", 64'(res_valid), 0);
        task_sw = 1;
        req_valid = 1;
        @(negedge clk);
        check("R2 b2b a", 64'(exc_code), 64'(C_NM));
        task_sw = 0;
        @(negedge clk);
        req_valid = 0;
        check("R2 b2b b valid", 64'(res_valid), 1);
        check("R2 b2b b code", 64'(exc_code), 64'(C_NONE));
    endtask

    task automatic t_features();
        clean(2'd1); feat_base = 0; fire_expect("R3 base", C_UD, 0);
        clean(2'd1); feat_opt = 0;  fire_expect("R3 opt", C_UD, 0);
        clean(2'd1); os_enable = 0; task_sw = 1; fire_expect("R3 os over R5", C_UD, 0);
    endtask

    task automatic t_prefixes();
        clean(2'd2); pfx_lock = 1; fire_expect("R4 lock", C_UD, 0);
        clean(2'd2); pfx_66 = 1;   fire_expect("R4 66", C_UD, 0);
        clean(2'd2); pfx_f3 = 1;   fire_expect("R4 f3", C_UD, 0);
        clean(2'd2); pfx_f2 = 1; eff_addr = 64'h1001; fire_expect("R4 f2 over R6", C_UD, 0);
    endtask

    task automatic t_task_sw();
        clean(2'd0); task_sw = 1; eff_addr = 64'h1004; fire_expect("R5 nm", C_NM, 0);
    endtask

    task automatic t_align();
        clean(2'd0); eff_addr = 64'h1020; fire_expect("R6 real", C_GP, 0);
        clean(2'd1); eff_addr = 64'h1001; ss_limit_bad = 1; fire_expect("R6 prot over ss", C_GP, 0);
        clean(2'd2); eff_addr = 64'h1008; noncanon = 1; uses_stack = 1;
        pf_hit = 1; pf_code = 32'h7; fire_expect("R6 long over ss", C_GP, 0);
    endtask

    task automatic t_real();
        clean(2'd0); eff_addr = 64'(65536 - OPSIZE); fire_expect("R7 last ok", C_NONE, 0);
        clean(2'd0); eff_addr = 64'(65536 - OPSIZE + 64); fire_expect("R7 over", C_GP, 0);
        clean(2'd0); seg_limit_bad = 1; ss_limit_bad = 1; noncanon = 1;
        fire_expect("R7 ignores", C_NONE, 0);
    endtask

    task automatic t_prot();
        clean(2'd1); seg_limit_bad = 1; fire_expect("R8 seg", C_GP, 0);
        clean(2'd1); ss_limit_bad = 1; fire_expect("R8 ss", C_SS, 0);
        clean(2'd1); seg_limit_bad = 1; ss_limit_bad = 1; fire_expect("R8 both", C_GP, 0);
        clean(2'd1); noncanon = 1; eff_addr = 64'h0010_0000; fire_expect("R8 ignores", C_NONE, 0);
    endtask

    task automatic t_long();
        clean(2'd2); noncanon = 1; uses_stack = 1; fire_expect("R9 stack", C_SS, 0);
        clean(2'd3); noncanon = 1; fire_expect("R9 general", C_GP, 0);
        clean(2'd2); seg_limit_bad = 1; ss_limit_bad = 1; eff_addr = 64'h0010_0000;
        fire_expect("R9 ignores", C_NONE, 0);
    endtask

    task automatic t_page();
        clean(2'd2); pf_hit = 1; pf_code = 32'h0000_0007; fire_expect("R10 pf", C_PF, 32'h7);
        clean(2'd1); pf_hit = 1; pf_code = 32'hDEAD_0002; ss_limit_bad = 1;
        fire_expect("R10 below ss", C_SS, 0);
        clean(2'd0); pf_hit = 1; pf_code = 32'h0000_0015; fire_expect("R10 real", C_PF, 32'h15);
    endtask

    task automatic t_clean();
        clean(2'd1); pf_code = 32'h55; fire_expect("R11 clean", C_NONE, 0);
        clean(2'd2); task_sw = 1; fire_expect("R12 nm err", C_NM, 0);
    endtask

    initial begin
        clean(2'd0);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_timing();
        t_features();
        t_prefixes();
        t_task_sw();
        t_align();
        t_real();
        t_prot();
        t_long();
        t_page();
        t_clean();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule